// File: doc/BRIEF.md
# NAND Data-Phase Strobe Generator

This block drives the read and write strobes of an asynchronous SDR NAND flash device during a data burst. Every strobe phase is a programmable number of controller clock cycles. A start pulse begins a burst, and a read/write select chooses which strobe toggles. A burst length sets how many bytes the burst carries. During a read the bus is sampled once per byte and the byte comes out with its index and a one-cycle valid strobe. A one-cycle done flag ends the burst.

Device access time is given in clock cycles. It is not absorbed by lengthening the read-low phase. Instead the capture point moves 0 to 3 cycles past the rising edge of the read strobe, so the read cycle stays as short as pulse width and cycle time allow. Only access time beyond that 3-cycle reach stretches the low phase. A capture that is still pending when the next byte's strobe falls is taken later, tagged with its own byte index. The chosen delay is written into a 2-bit field of an 8-bit control register, and the other bits of that register are left as they were.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset and while idle, re_no and we_no are 1, data_valid_o and done_o are 0, and ctrl_o is 0 after reset.
- R2: A read burst carries len_i+1 bytes. For each byte re_no is 0 for Lr cycles and then 1 for twh_i+1 cycles, and the next byte's low phase starts straight after. The first low phase begins on the clock edge that accepts the start.
- R3: A write burst carries len_i+1 bytes. For each byte we_no is 0 for twst_i+1 cycles and then 1 for twh_i+1 cycles, re_no stays 1 and no byte is captured.
- R4: Each read byte samples dq_i on the clock edge d cycles after the edge where re_no returns to 1; d=0 samples on that edge itself. The sampled byte appears on data_o with data_valid_o=1 for the single following cycle.
- R5: With L=trlt_i+1, need = tacc_i-L when tacc_i>L and 0 otherwise. The delay is d=min(need,3). The read low length is Lr=L+need-3 when need>3 and Lr=L otherwise.
- R6: A write with ctrl_we_i loads ctrl_o from ctrl_wdata_i. Each accepted start then writes d into ctrl_o[4:3] and leaves bits 7:5 and 2:0 unchanged.
- R7: Each read byte is captured exactly once and in order, with data_idx_o equal to its index 0..len_i. This holds even when its delayed sample falls after the next byte's falling strobe.
- R8: All timing fields, len_i and rd_i are taken on the accepted start. Changes to them during a burst, and start pulses during a burst, have no effect on that burst.
- R9: done_o is 1 for exactly one cycle. It is set on the first edge that is both at least one cycle after the last high phase ends and at least one cycle after the last byte's sample edge.
- R10: re_no and we_no are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst start pulse, taken only when idle |
| rd_i | input | 1 | 1 for read burst, 0 for write burst |
| len_i | input | 8 | Byte count minus one |
| trlt_i | input | 4 | Read low length minus one |
| twh_i | input | 4 | Strobe high length minus one |
| twst_i | input | 4 | Write low length minus one |
| tacc_i | input | 5 | Device access time in cycles from the read strobe falling |
| dq_i | input | 8 | Flash data bus |
| ctrl_we_i | input | 1 | Full write strobe for the control register |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_o | output | 8 | Control register contents, delay in bits 4:3 |
| re_no | output | 1 | Read strobe, active low |
| we_no | output | 1 | Write strobe, active low |
| data_o | output | 8 | Captured byte |
| data_idx_o | output | 8 | Index of the captured byte within the burst |
| data_valid_o | output | 1 | data_o and data_idx_o valid |
| done_o | output | 1 | Burst complete pulse |

## Verification
A phase counter that loads the wrong length shows within one byte as a strobe edge off by some cycles. A wrong delay or a lost pending slot shows as a captured value that does not match the sample edge, or as a missing or repeated index. The bench drives dq_i with a running cycle count, so every captured byte states the exact edge at which it was sampled. A drain state that ends too early or waits too long moves done_o relative to the last capture, and that shows at the end of the same burst.

// File: rtl/nsg_pkg.sv
package nsg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI, ST_DRAIN} seq_state_e;
endpackage

// File: rtl/nsg_calc.sv
module nsg_calc #(
  parameter int CNT_W = 4,
  parameter int ACC_W = 5,
  parameter int DLY_W = 2,
  parameter int LOW_W = 6
) (
  input  logic [CNT_W-1:0] trlt_i,
  input  logic [ACC_W-1:0] tacc_i,
  output logic [LOW_W-1:0] low_m1_o,
  output logic [DLY_W-1:0] dly_o
);
  localparam int MAX_DLY = (1 << DLY_W) - 1;

  logic [LOW_W-1:0] base_len, acc_ext, need;

  always_comb begin
    base_len = LOW_W'(trlt_i) + LOW_W'(1);
    acc_ext  = LOW_W'(tacc_i);
    need     = (acc_ext > base_len) ? (acc_ext - base_len) : '0;
    if (need > LOW_W'(MAX_DLY)) begin
      // delay saturates, remainder stretches the low phase
      dly_o    = DLY_W'(MAX_DLY);
      low_m1_o = LOW_W'(trlt_i) + need - LOW_W'(MAX_DLY);
    end else begin
      dly_o    = need[DLY_W-1:0];
      low_m1_o = LOW_W'(trlt_i);
    end
  end
endmodule

// File: rtl/nsg_seq.sv
module nsg_seq
  import nsg_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LOW_W = 6,
  parameter int DLY_W = 2,
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LOW_W-1:0] low_m1_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [CNT_W-1:0] twh_i,
  input  logic [CNT_W-1:0] twst_i,
  input  logic             pend_any_i,
  output logic             busy_o,
  output logic             rise_o,
  output logic [LEN_W-1:0] idx_o,
  output logic [DLY_W-1:0] dly_o,
  output logic             re_no,
  output logic             we_no,
  output logic             done_o
);
  seq_state_e       state_q;
  logic [LOW_W-1:0] cnt_q, low_m1_q;
  logic [CNT_W-1:0] twh_q;
  logic [DLY_W-1:0] dly_q;
  logic [LEN_W-1:0] byte_q, last_q;
  logic             is_rd_q, re_q, we_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      low_m1_q <= '0;
      twh_q    <= '0;
      dly_q    <= '0;
      byte_q   <= '0;
      last_q   <= '0;
      is_rd_q  <= 1'b0;
      re_q     <= 1'b1;
      we_q     <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          is_rd_q  <= rd_i;
          low_m1_q <= rd_i ? low_m1_i : LOW_W'(twst_i);
          cnt_q    <= rd_i ? low_m1_i : LOW_W'(twst_i);
          twh_q    <= twh_i;
          dly_q    <= dly_i;
          last_q   <= len_i;
          byte_q   <= '0;
          re_q     <= ~rd_i;
          we_q     <= rd_i;
          state_q  <= ST_LO;
        end
        ST_LO: begin
          if (cnt_q == '0) begin
            re_q    <= 1'b1;
            we_q    <= 1'b1;
            cnt_q   <= LOW_W'(twh_q);
            state_q <= ST_HI;
          end else begin
            cnt_q <= cnt_q - LOW_W'(1);
          end
        end
        ST_HI: begin
          if (cnt_q == '0) begin
            if (byte_q == last_q) begin
              state_q <= ST_DRAIN;
            end else begin
              byte_q  <= byte_q + LEN_W'(1);
              cnt_q   <= low_m1_q;
              re_q    <= ~is_rd_q;
              we_q    <= is_rd_q;
              state_q <= ST_LO;
            end
          end else begin
            cnt_q <= cnt_q - LOW_W'(1);
          end
        end
        ST_DRAIN: if (!pend_any_i) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign rise_o = (state_q == ST_LO) && (cnt_q == '0) && is_rd_q;
  assign idx_o  = byte_q;
  assign dly_o  = dly_q;
  assign re_no  = re_q;
  assign we_no  = we_q;
  assign done_o = done_q;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_q || we_q) else $error("strobes both low"); // R10
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (re_q && we_q)) else $error("strobe low while idle"); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R9
  AST_LO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LO && cnt_q != '0) |=> (state_q == ST_LO && $stable(re_q))) else $error("low phase cut short"); // R2
  AST_FIELDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q == ST_IDLE) || ($stable(low_m1_q) && $stable(twh_q) && $stable(last_q))) else $error("fields changed mid burst"); // R8
endmodule

// File: rtl/nsg_sample.sv
module nsg_sample #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter int DLY_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic [LEN_W-1:0]  idx_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              pend_any_o,
  output logic [DATA_W-1:0] data_o,
  output logic [LEN_W-1:0]  idx_o,
  output logic              valid_o
);
  localparam int MAX_DLY = (1 << DLY_W) - 1;

  logic [MAX_DLY-1:0] pend_q, pend_d;
  logic [LEN_W-1:0]   tag_q [MAX_DLY];
  logic [LEN_W-1:0]   tag_d [MAX_DLY];
  logic               cap_now;
  logic [LEN_W-1:0]   cap_tag;
  logic [DATA_W-1:0]  data_q;
  logic [LEN_W-1:0]   idx_q;
  logic               valid_q;

  // slot 0 fires on the next edge; a new token enters at slot dly-1
  always_comb begin
    pend_d = pend_q >> 1;
    for (int i = 0; i < MAX_DLY; i++) begin
      tag_d[i] = (i < MAX_DLY - 1) ? tag_q[(i + 1) % MAX_DLY] : tag_q[i];
    end
    if (rise_i && dly_i != '0) begin
      pend_d[int'(dly_i) - 1] = 1'b1;
      tag_d[int'(dly_i) - 1]  = idx_i;
    end
  end

  assign cap_now = (rise_i && dly_i == '0) || pend_q[0];
  assign cap_tag = pend_q[0] ? tag_q[0] : idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      for (int i = 0; i < MAX_DLY; i++) tag_q[i] <= '0;
      data_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      for (int i = 0; i < MAX_DLY; i++) tag_q[i] <= tag_d[i];
      valid_q <= cap_now;
      if (cap_now) begin
        data_q <= dq_i;
        idx_q  <= cap_tag;
      end
    end
  end

  assign pend_any_o = |pend_q;
  assign data_o     = data_q;
  assign idx_o      = idx_q;
  assign valid_o    = valid_q;

  AST_PEND_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pend_q) <= 2) else $error("too many pending samples"); // R7
  AST_NO_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_i && dly_i == '0 && pend_q[0])) else $error("two captures on one edge"); // R7
  AST_IDX_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && $past(valid_q) && idx_q != '0) |-> (idx_q == $past(idx_q) + LEN_W'(1))) else $error("capture order"); // R7
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen #(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 8,
  parameter int CNT_W   = 4,
  parameter int ACC_W   = 5,
  parameter int DLY_W   = 2,
  parameter int CTRL_W  = 8,
  parameter int DLY_LSB = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CNT_W-1:0]  trlt_i,
  input  logic [CNT_W-1:0]  twh_i,
  input  logic [CNT_W-1:0]  twst_i,
  input  logic [ACC_W-1:0]  tacc_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              re_no,
  output logic              we_no,
  output logic [DATA_W-1:0] data_o,
  output logic [LEN_W-1:0]  data_idx_o,
  output logic              data_valid_o,
  output logic              done_o
);
  localparam int LOW_W = ((CNT_W > ACC_W) ? CNT_W : ACC_W) + 1;
  localparam logic [CTRL_W-1:0] DLY_MASK = CTRL_W'(((1 << DLY_W) - 1) << DLY_LSB);

  logic [LOW_W-1:0]  calc_low_m1;
  logic [DLY_W-1:0]  calc_dly, run_dly;
  logic              busy, start_ok, rise, pend_any;
  logic [LEN_W-1:0]  rise_idx;
  logic [CTRL_W-1:0] ctrl_q;

  assign start_ok = start_i && !busy;

  nsg_calc #(.CNT_W(CNT_W), .ACC_W(ACC_W), .DLY_W(DLY_W), .LOW_W(LOW_W)) u_calc (
    .trlt_i  (trlt_i),
    .tacc_i  (tacc_i),
    .low_m1_o(calc_low_m1),
    .dly_o   (calc_dly)
  );

  nsg_seq #(.CNT_W(CNT_W), .LOW_W(LOW_W), .DLY_W(DLY_W), .LEN_W(LEN_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_ok),
    .rd_i      (rd_i),
    .len_i     (len_i),
    .low_m1_i  (calc_low_m1),
    .dly_i     (calc_dly),
    .twh_i     (twh_i),
    .twst_i    (twst_i),
    .pend_any_i(pend_any),
    .busy_o    (busy),
    .rise_o    (rise),
    .idx_o     (rise_idx),
    .dly_o     (run_dly),
    .re_no     (re_no),
    .we_no     (we_no),
    .done_o    (done_o)
  );

  nsg_sample #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DLY_W(DLY_W)) u_sample (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .idx_i     (rise_idx),
    .dly_i     (run_dly),
    .dq_i      (dq_i),
    .pend_any_o(pend_any),
    .data_o    (data_o),
    .idx_o     (data_idx_o),
    .valid_o   (data_valid_o)
  );

  // field update on start only touches the delay bits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
      if (start_ok)  ctrl_q[DLY_LSB +: DLY_W] <= calc_dly;
    end
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_q & ~DLY_MASK)) else $error("ctrl bits outside field changed"); // R6
  AST_CTRL_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok |=> (ctrl_q[DLY_LSB +: DLY_W] == $past(calc_dly))) else $error("delay field not written"); // R6
  AST_VALID_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> $past(busy)) else $error("capture while idle"); // R3
endmodule

// File: tb/sim_nand_strobe_gen.sv
module sim_nand_strobe_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, rd_i = 1'b0, ctrl_we = 1'b0;
  logic [7:0] len_i = '0, dq_i = '0, ctrl_wdata = '0, ctrl_o, data_o, idx_o;
  logic [3:0] trlt_i = '0, twh_i = '0, twst_i = '0;
  logic [4:0] tacc_i = '0;
  logic re_no, we_no, valid_o, done_o;

  int checks = 0, errors = 0, ncnt = 0, gcnt = 0;
  int n_ref, n_rer, n_wef, n_wer, ncap, ndone, excl_bad;
  int ref_t[64], rer_t[64], wef_t[64], wer_t[64], cap_t[64], cap_d[64], cap_i[64];
  int done_t;
  logic re_prev = 1'b1, we_prev = 1'b1;
  int ctrl_exp;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_strobe_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .rd_i(rd_i), .len_i(len_i),
    .trlt_i(trlt_i), .twh_i(twh_i), .twst_i(twst_i), .tacc_i(tacc_i), .dq_i(dq_i),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_o(ctrl_o),
    .re_no(re_no), .we_no(we_no), .data_o(data_o), .data_idx_o(idx_o),
    .data_valid_o(valid_o), .done_o(done_o)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    gcnt++;
    if (gcnt > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", gcnt);
      summary();
      $finish;
    end
  end

  // observation: output changes made at the edge that sampled dq=t are logged as t
  always @(negedge clk) begin
    if (rst_n) begin
      if (re_prev && !re_no && n_ref < 64) begin ref_t[n_ref] = ncnt; n_ref++; end
      if (!re_prev && re_no && n_rer < 64) begin rer_t[n_rer] = ncnt; n_rer++; end
      if (we_prev && !we_no && n_wef < 64) begin wef_t[n_wef] = ncnt; n_wef++; end
      if (!we_prev && we_no && n_wer < 64) begin wer_t[n_wer] = ncnt; n_wer++; end
      if (valid_o && ncap < 64) begin
        cap_t[ncap] = ncnt; cap_d[ncap] = int'(data_o); cap_i[ncap] = int'(idx_o); ncap++;
      end
      if (done_o) begin done_t = ncnt; ndone++; end
      if (!re_no && !we_no) excl_bad++;
    end
    re_prev = re_no;
    we_prev = we_no;
    ncnt++;
    dq_i = ncnt[7:0];
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input bit rd, input int trlt, input int twh, input int twst,
                     input int tacc, input int len);
    int s, l, need, d, lr, h, p, nb, ph, ts_last, dexp, w;
    l = trlt + 1;
    need = (tacc > l) ? tacc - l : 0;           // R5
    d = (need > 3) ? 3 : need;
    lr = (need > 3) ? l + need - 3 : l;
    if (!rd) lr = twst + 1;
    h = twh + 1;
    p = lr + h;
    nb = len + 1;
    @(negedge clk); #1;
    n_ref = 0; n_rer = 0; n_wef = 0; n_wer = 0; ncap = 0; ndone = 0;
    s = ncnt;
    rd_i = rd; trlt_i = 4'(trlt); twh_i = 4'(twh); twst_i = 4'(twst);
    tacc_i = 5'(tacc); len_i = 8'(len); start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    // R8: disturb every field after the accepting edge
    trlt_i = ~trlt_i; twh_i = ~twh_i; twst_i = ~twst_i; tacc_i = ~tacc_i;
    len_i = len_i + 8'd5; rd_i = ~rd_i;
    @(negedge clk); #1;
    start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    w = 0;
    while (ndone == 0 && w < 4000) begin @(negedge clk); #1; w++; end
    repeat (6) @(negedge clk);
    #1;
    ph = s + nb * p;
    if (rd) begin
      chk("R2 read fall count", n_ref, nb);
      chk("R2 read rise count", n_rer, nb);
      chk("R3 no write strobe in read", n_wef, 0);
      for (int b = 0; b < nb && b < n_ref && b < n_rer; b++) begin
        chk("R2 read fall edge", ref_t[b], s + b * p);
        chk("R5 read low length", rer_t[b] - ref_t[b], lr);
      end
      chk("R7 capture count", ncap, nb);
      for (int b = 0; b < nb && b < ncap; b++) begin
        chk("R4 sample edge", cap_t[b], s + b * p + lr + d);
        chk("R4 sampled byte", cap_d[b], (s + b * p + lr + d) % 256);
        chk("R7 byte index", cap_i[b], b);
      end
      ts_last = s + (nb - 1) * p + lr + d;
      dexp = (ph + 1 > ts_last + 1) ? ph + 1 : ts_last + 1;
    end else begin
      chk("R3 write fall count", n_wef, nb);
      chk("R3 write rise count", n_wer, nb);
      chk("R3 no read strobe in write", n_ref, 0);
      chk("R3 no capture in write", ncap, 0);
      for (int b = 0; b < nb && b < n_wef && b < n_wer; b++) begin
        chk("R3 write fall edge", wef_t[b], s + b * p);
        chk("R3 write low length", wer_t[b] - wef_t[b], lr);
      end
      dexp = ph + 1;
    end
    chk("R9 done count", ndone, 1);
    if (ndone > 0) chk("R9 done edge", done_t, dexp);
    chk("R1 idle strobes high", int'({re_no, we_no}), 3);
    ctrl_exp = (ctrl_exp & 'hE7) | (d << 3);
    chk("R6 ctrl register", int'(ctrl_o), ctrl_exp);
  endtask

  initial begin
    n_ref = 0; n_rer = 0; n_wef = 0; n_wer = 0; ncap = 0; ndone = 0; excl_bad = 0; done_t = 0;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset re_no", int'(re_no), 1);
    chk("R1 reset we_no", int'(we_no), 1);
    chk("R1 reset valid", int'(valid_o), 0);
    chk("R1 reset done", int'(done_o), 0);
    chk("R1 reset ctrl", int'(ctrl_o), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    ctrl_wdata = 8'hA5; ctrl_we = 1'b1;
    @(negedge clk); #1;
    ctrl_we = 1'b0;
    ctrl_exp = 'hA5;
    chk("R6 full write", int'(ctrl_o), ctrl_exp);
    for (int tr = 0; tr < 4; tr++)
      for (int th = 0; th < 3; th++)
        for (int ta = 0; ta < 13; ta++)
          run(1'b1, tr, th, 0, ta, (tr + th + ta) % 4);
    @(negedge clk); #1;
    ctrl_wdata = 8'h5A; ctrl_we = 1'b1;
    @(negedge clk); #1;
    ctrl_we = 1'b0;
    ctrl_exp = 'h5A;
    chk("R6 second full write", int'(ctrl_o), ctrl_exp);
    run(1'b1, 0, 0, 0, 31, 3);   // R5 deep saturation
    run(1'b1, 15, 0, 0, 31, 2);
    run(1'b1, 15, 15, 0, 0, 1);
    run(1'b1, 1, 0, 0, 5, 3);    // R7 pending sample crosses next fall
    for (int tw = 0; tw < 4; tw++)
      for (int th = 0; th < 3; th++)
        run(1'b0, 0, th, tw, tw + th, (tw + th) % 4);
    chk("R10 strobes never both low", excl_bad, 0);
    summary();
    $finish;
  end
endmodule